// File: doc/BRIEF.md
# Secure-Filtered Interrupt Bitmap Bank

This block keeps three per-interrupt state bitmaps (enable, pending and active) for the shared interrupts of an interrupt controller. It exposes them through a word-addressed register interface. Each bitmap has a set window, where a written 1 sets a bit, and a clear window, where a written 1 clears a bit. Every read and write carries a secure attribute. When security is in force, a non-secure access reaches only the bits that a per-access permission mask allows. The mask is built from the interrupt's group bit and its 2-bit non-secure access code.

Interrupt numbers 0 to 31 are internal to the processors and have no storage here. Bit j of every vector port stands for interrupt 32+j. A level input per interrupt is registered every cycle. A rising level on a line configured as edge-triggered latches that line's pending bit. For a level-triggered line, the pending value that is read back is the latch ORed with the registered level. Reads answer one cycle after the request. Writes use a request/ready handshake, and a read in the same cycle takes precedence over a write.

Top module: `irq_bitmap_bank`

## Requirements
- R1: Address bits [IDX_W-1:0] give a word index w that covers interrupts 32w to 32w+31, and bits [IDX_W+2:IDX_W] select a window: 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear, 4 active-set, 5 active-clear, 6 and 7 reserved. Word 0, words at or above NUM_IRQ/32, and the reserved windows read as zero and ignore writes.
- R2: In a set window, each written 1 sets the matching bitmap bit, and each written 0 leaves it unchanged. A set window and its clear window read back the same bitmap.
- R3: In a clear window, each written 1 clears the matching bit, and each written 0 leaves it unchanged. Without an accepted write, the enable and active bitmaps do not change.
- R4: A secure access, or any access while sec_disable_i is 1, reads and writes every bit with no filtering.
- R5: For a non-secure access while security is in force, enable-window bits are reachable only where grp_i is 1. Other bits read as 0 and are left unchanged by writes.
- R6: For such an access to the pending-set window, a bit is reachable where its group bit is 1 or its access code (acc_code_i[2j+1:2j] for interrupt 32+j) is 1 or more.
- R7: For such an access to the pending-clear window, a bit is reachable, for reads and writes, where its group bit is 1 or its access code is 2 or more.
- R8: For such an access to an active window, reads see bits where the group bit is 1 or the access code is 2 or more. Writes change only bits whose group bit is 1.
- R9: The pending value (read data and pending_o) equals the latch ORed with (registered level AND NOT edge_cfg_i). The level is registered one cycle after level_i.
- R10: A 0-to-1 change of level_i on an edge-configured line sets its pending latch. A level held high does not set the latch again. When a clear write and a latching edge hit the same bit in the same cycle, the bit ends set.
- R11: rd_valid_o rises in the cycle after rd_req_i, with rd_data_o. wr_ready_o is 0 whenever rd_req_i is 1. A write takes effect only on a cycle where wr_req_i and wr_ready_o are both 1.
- R12: After reset, all bitmaps are zero and rd_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_disable_i | input | 1 | 1 removes all security filtering |
| grp_i | input | NUM_IRQ-32 | Group bit per interrupt (1 = non-secure group) |
| acc_code_i | input | 2*(NUM_IRQ-32) | Non-secure access code, 2 bits per interrupt |
| edge_cfg_i | input | NUM_IRQ-32 | 1 = edge-triggered, 0 = level-triggered |
| level_i | input | NUM_IRQ-32 | Interrupt input lines |
| wr_req_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Write accepted this cycle when high with wr_req_i |
| wr_addr_i | input | IDX_W+3 | Write window and word index |
| wr_data_i | input | 32 | Write data |
| wr_secure_i | input | 1 | Write is secure |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | IDX_W+3 | Read window and word index |
| rd_secure_i | input | 1 | Read is secure |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Filtered read data |
| enabled_o | output | NUM_IRQ-32 | Enable bitmap |
| pending_o | output | NUM_IRQ-32 | Effective pending bitmap |
| active_o | output | NUM_IRQ-32 | Active bitmap |

## Verification
The hardest case to reach is a clear write and a latching edge that land on the same pending bit in the same clock. The stimulus raises that line's level and issues a secure pending-clear write of the bit in one driver step, so both reach the same edge. A less obvious case is a line whose level stays high after software has cleared its latch. The bench clears the latch while the level is held, waits several cycles and reads the bit back, so any re-latching from the steady level would show. The non-secure tests use one word in which the group bits and all four access codes are mixed. Each window's filter is then compared through secure and non-secure reads of the same word.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
   localparam int WORD_W = 32;
   localparam int WIN_W  = 3;

   typedef enum logic [WIN_W-1:0] {
      WIN_EN_SET = 3'd0,
      WIN_EN_CLR = 3'd1,
      WIN_PD_SET = 3'd2,
      WIN_PD_CLR = 3'd3,
      WIN_AC_SET = 3'd4,
      WIN_AC_CLR = 3'd5,
      WIN_RSV_A  = 3'd6,
      WIN_RSV_B  = 3'd7
   } win_e;

   // Permission masks for one 32-interrupt word, already widened by bypass
   typedef struct packed {
      logic [WORD_W-1:0] grp_only;
      logic [WORD_W-1:0] ge1;
      logic [WORD_W-1:0] ge2;
   } mask_set_t;

   function automatic logic win_is_set(win_e w);
      logic [WIN_W-1:0] v;
      v = w;
      return ~v[0];
   endfunction

   function automatic logic [1:0] win_map(win_e w);
      logic [WIN_W-1:0] v;
      v = w;
      return v[2:1];
   endfunction
endpackage

// File: rtl/ibb_mask_gen.sv
module ibb_mask_gen
   import ibb_pkg::*;
(
   input  logic [WORD_W-1:0]   grp_w,
   input  logic [2*WORD_W-1:0] code_w,
   input  logic                bypass,
   output mask_set_t           masks
);
   logic [WORD_W-1:0] any_code;
   logic [WORD_W-1:0] high_code;

   // Fold two code bits per interrupt down to one bit per threshold
   for (genvar k = 0; k < WORD_W; k++) begin : g_fold
      assign any_code[k]  = code_w[2*k] | code_w[2*k+1];
      assign high_code[k] = code_w[2*k+1];
   end

   always_comb begin
      masks.grp_only = bypass ? '1 : grp_w;
      masks.ge1      = bypass ? '1 : (grp_w | any_code);
      masks.ge2      = bypass ? '1 : (grp_w | high_code);
   end
endmodule

// File: rtl/ibb_access_path.sv
module ibb_access_path
   import ibb_pkg::*;
#(
   parameter  int NUM_IRQ   = 64,
   parameter  int IDX_W     = 5,
   localparam int NUM_EXT   = NUM_IRQ - WORD_W,
   localparam int EXT_WORDS = NUM_EXT / WORD_W,
   localparam int ADDR_W    = IDX_W + WIN_W
)(
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 secure,
   input  logic                 sec_disable,
   input  logic [NUM_EXT-1:0]   grp_i,
   input  logic [2*NUM_EXT-1:0] code_i,
   output logic                 hit,
   output win_e                 win,
   output logic [IDX_W-1:0]     ext_idx,
   output mask_set_t            masks
);
   logic [IDX_W-1:0]    word_idx;
   logic                in_range;
   logic [WORD_W-1:0]   grp_w;
   logic [2*WORD_W-1:0] code_w;

   assign word_idx = addr[IDX_W-1:0];
   assign in_range = (word_idx != '0) &&
                     ({1'b0, word_idx} <= (IDX_W+1)'(EXT_WORDS));
   assign win      = win_e'(addr[ADDR_W-1:IDX_W]);
   assign hit      = in_range && (addr[ADDR_W-1 -: 2] != 2'b11);
   assign ext_idx  = in_range ? (word_idx - IDX_W'(1)) : '0;

   always_comb begin
      grp_w  = '0;
      code_w = '0;
      for (int w = 0; w < EXT_WORDS; w++) begin
         if (ext_idx == IDX_W'(w)) begin
            grp_w  = grp_i[w*WORD_W +: WORD_W];
            code_w = code_i[w*2*WORD_W +: 2*WORD_W];
         end
      end
   end

   ibb_mask_gen u_mask (
      .grp_w  (grp_w),
      .code_w (code_w),
      .bypass (secure | sec_disable),
      .masks  (masks)
   );
endmodule

// File: rtl/ibb_bitmap.sv
module ibb_bitmap
   import ibb_pkg::*;
#(
   parameter  int NUM_EXT   = 32,
   parameter  int IDX_W     = 5,
   localparam int EXT_WORDS = NUM_EXT / WORD_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic               set_op,
   input  logic [IDX_W-1:0]   idx,
   input  logic [WORD_W-1:0]  data,
   input  logic [NUM_EXT-1:0] hw_set,
   output logic [NUM_EXT-1:0] q
);
   for (genvar wi = 0; wi < EXT_WORDS; wi++) begin : g_word
      logic [WORD_W-1:0] cur;
      logic [WORD_W-1:0] nxt;
      logic              sel;

      assign cur = q[wi*WORD_W +: WORD_W];
      assign sel = we && (idx == IDX_W'(wi));

      // Software update first, hardware set last so that it wins
      always_comb begin
         nxt = cur;
         if (sel) begin
            nxt = set_op ? (cur | data) : (cur & ~data);
         end
         nxt = nxt | hw_set[wi*WORD_W +: WORD_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[wi*WORD_W +: WORD_W] <= '0;
         end else begin
            q[wi*WORD_W +: WORD_W] <= nxt;
         end
      end
   end
endmodule

// File: rtl/ibb_level_track.sv
module ibb_level_track #(
   parameter int NUM_EXT = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] level_i,
   input  logic [NUM_EXT-1:0] edge_cfg_i,
   output logic [NUM_EXT-1:0] level_q,
   output logic [NUM_EXT-1:0] edge_hit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else begin
         level_q <= level_i;
      end
   end

   // A held level equals level_q and produces no hit
   assign edge_hit = edge_cfg_i & level_i & ~level_q;
endmodule

// File: rtl/irq_bitmap_bank.sv
module irq_bitmap_bank
   import ibb_pkg::*;
#(
   parameter  int NUM_IRQ   = 64,
   parameter  int IDX_W     = 5,
   localparam int NUM_EXT   = NUM_IRQ - WORD_W,
   localparam int EXT_WORDS = NUM_EXT / WORD_W,
   localparam int ADDR_W    = IDX_W + WIN_W,
   localparam int N_MAPS    = 3
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sec_disable_i,
   input  logic [NUM_EXT-1:0]   grp_i,
   input  logic [2*NUM_EXT-1:0] acc_code_i,
   input  logic [NUM_EXT-1:0]   edge_cfg_i,
   input  logic [NUM_EXT-1:0]   level_i,
   input  logic                 wr_req_i,
   output logic                 wr_ready_o,
   input  logic [ADDR_W-1:0]    wr_addr_i,
   input  logic [WORD_W-1:0]    wr_data_i,
   input  logic                 wr_secure_i,
   input  logic                 rd_req_i,
   input  logic [ADDR_W-1:0]    rd_addr_i,
   input  logic                 rd_secure_i,
   output logic                 rd_valid_o,
   output logic [WORD_W-1:0]    rd_data_o,
   output logic [NUM_EXT-1:0]   enabled_o,
   output logic [NUM_EXT-1:0]   pending_o,
   output logic [NUM_EXT-1:0]   active_o
);
   // Elaboration-time parameter checks
   if ((NUM_IRQ % WORD_W) != 0 || NUM_IRQ < 64 || NUM_IRQ > 1024) begin : g_bad_count
      $error("NUM_IRQ must be a multiple of 32 from 64 to 1024");
   end
   if ((2 ** IDX_W) < (NUM_IRQ / WORD_W)) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_IRQ");
   end

   // ---------------- write side ----------------
   logic              wr_fire;
   logic              w_hit;
   win_e              w_win;
   logic [IDX_W-1:0]  w_idx;
   mask_set_t         w_masks;
   logic [WORD_W-1:0] w_mask;
   logic [WORD_W-1:0] w_data_m;

   assign wr_ready_o = ~rd_req_i;
   assign wr_fire    = wr_req_i & wr_ready_o;

   ibb_access_path #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_wpath (
      .addr        (wr_addr_i),
      .secure      (wr_secure_i),
      .sec_disable (sec_disable_i),
      .grp_i       (grp_i),
      .code_i      (acc_code_i),
      .hit         (w_hit),
      .win         (w_win),
      .ext_idx     (w_idx),
      .masks       (w_masks)
   );

   // Active windows are read-only to code-granted non-secure writers
   always_comb begin
      unique case (w_win)
         WIN_PD_SET: w_mask = w_masks.ge1;
         WIN_PD_CLR: w_mask = w_masks.ge2;
         default:    w_mask = w_masks.grp_only;
      endcase
   end
   assign w_data_m = wr_data_i & w_mask;

   // ---------------- level sampling ----------------
   logic [NUM_EXT-1:0] lvl_q;
   logic [NUM_EXT-1:0] edge_hit;

   ibb_level_track #(.NUM_EXT(NUM_EXT)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (level_i),
      .edge_cfg_i (edge_cfg_i),
      .level_q    (lvl_q),
      .edge_hit   (edge_hit)
   );

   // ---------------- bitmaps: 0 enable, 1 pending latch, 2 active ----------------
   logic [NUM_EXT-1:0] bm_q  [N_MAPS];
   logic [NUM_EXT-1:0] bm_hw [N_MAPS];

   assign bm_hw[0] = '0;
   assign bm_hw[1] = edge_hit;
   assign bm_hw[2] = '0;

   for (genvar g = 0; g < N_MAPS; g++) begin : g_map
      ibb_bitmap #(.NUM_EXT(NUM_EXT), .IDX_W(IDX_W)) u_bm (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (wr_fire && w_hit && (win_map(w_win) == 2'(g))),
         .set_op (win_is_set(w_win)),
         .idx    (w_idx),
         .data   (w_data_m),
         .hw_set (bm_hw[g]),
         .q      (bm_q[g])
      );
   end

   logic [NUM_EXT-1:0] pend_eff;
   assign pend_eff  = bm_q[1] | (lvl_q & ~edge_cfg_i);
   assign enabled_o = bm_q[0];
   assign pending_o = pend_eff;
   assign active_o  = bm_q[2];

   // ---------------- read side ----------------
   logic               r_hit;
   win_e               r_win;
   logic [IDX_W-1:0]   r_idx;
   mask_set_t          r_masks;
   logic [WORD_W-1:0]  r_mask;
   logic [NUM_EXT-1:0] r_vec;
   logic [WORD_W-1:0]  r_raw;
   logic               rd_valid_q;
   logic [WORD_W-1:0]  rd_data_q;

   ibb_access_path #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_rpath (
      .addr        (rd_addr_i),
      .secure      (rd_secure_i),
      .sec_disable (sec_disable_i),
      .grp_i       (grp_i),
      .code_i      (acc_code_i),
      .hit         (r_hit),
      .win         (r_win),
      .ext_idx     (r_idx),
      .masks       (r_masks)
   );

   always_comb begin
      unique case (r_win)
         WIN_EN_SET, WIN_EN_CLR: r_mask = r_masks.grp_only;
         WIN_PD_SET:             r_mask = r_masks.ge1;
         default:                r_mask = r_masks.ge2;
      endcase
      unique case (win_map(r_win))
         2'd0:    r_vec = bm_q[0];
         2'd1:    r_vec = pend_eff;
         default: r_vec = bm_q[2];
      endcase
      r_raw = '0;
      for (int w = 0; w < EXT_WORDS; w++) begin
         if (r_idx == IDX_W'(w)) begin
            r_raw = r_vec[w*WORD_W +: WORD_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= rd_req_i;
         rd_data_q  <= (rd_req_i && r_hit) ? (r_raw & r_mask) : '0;
      end
   end

   assign rd_valid_o = rd_valid_q;
   assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/ibb_checker.sv
module ibb_checker #(
   parameter  int NUM_IRQ   = 64,
   parameter  int IDX_W     = 5,
   localparam int NUM_EXT   = NUM_IRQ - 32,
   localparam int EXT_WORDS = NUM_EXT / 32,
   localparam int ADDR_W    = IDX_W + 3
)(
   input logic               clk,
   input logic               rst_n,
   input logic               sec_disable_i,
   input logic [NUM_EXT-1:0] grp_i,
   input logic [NUM_EXT-1:0] edge_cfg_i,
   input logic [NUM_EXT-1:0] level_i,
   input logic               wr_req_i,
   input logic               wr_ready_o,
   input logic [ADDR_W-1:0]  wr_addr_i,
   input logic               wr_secure_i,
   input logic               rd_req_i,
   input logic [ADDR_W-1:0]  rd_addr_i,
   input logic               rd_valid_o,
   input logic [31:0]        rd_data_o,
   input logic [NUM_EXT-1:0] enabled_o,
   input logic [NUM_EXT-1:0] pending_o,
   input logic [NUM_EXT-1:0] active_o
);
   logic [1:0]       up_cnt;
   logic             wr_fire;
   logic             rd_bad;
   logic [IDX_W-1:0] rd_idx;
   logic [2:0]       wr_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_cnt <= '0;
      end else if (up_cnt != 2'd3) begin
         up_cnt <= up_cnt + 2'd1;
      end
   end

   assign wr_fire = wr_req_i & wr_ready_o;
   assign rd_idx  = rd_addr_i[IDX_W-1:0];
   assign rd_bad  = (rd_idx == '0) || ({1'b0, rd_idx} > (IDX_W+1)'(EXT_WORDS)) ||
                    (rd_addr_i[ADDR_W-1 -: 2] == 2'b11);
   assign wr_win  = wr_addr_i[ADDR_W-1:IDX_W];

   p_range_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && rd_bad) |=> (rd_data_o == '0));

   p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && wr_win == 3'd0) |=> (($past(enabled_o) & ~enabled_o) == '0));

   p_clr_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && wr_win == 3'd1) |=> ((enabled_o & ~$past(enabled_o)) == '0));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_fire |=> ($stable(enabled_o) && $stable(active_o)));

   p_ns_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !wr_secure_i && !sec_disable_i) |=>
      (((enabled_o ^ $past(enabled_o)) & ~$past(grp_i)) == '0));

   p_ns_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !wr_secure_i && !sec_disable_i) |=>
      (((active_o ^ $past(active_o)) & ~$past(grp_i)) == '0));

   p_level_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt != 2'd0) |-> ((~edge_cfg_i & $past(level_i) & ~pending_o) == '0));

   p_edge_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt >= 2'd2) |->
      (($past(edge_cfg_i) & $past(level_i) & ~$past(level_i, 2) & ~pending_o) == '0));

   p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_i |=> rd_valid_o);

   p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req_i |=> !rd_valid_o);
endmodule

bind irq_bitmap_bank ibb_checker #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_ibb_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sec_disable_i (sec_disable_i),
   .grp_i         (grp_i),
   .edge_cfg_i    (edge_cfg_i),
   .level_i       (level_i),
   .wr_req_i      (wr_req_i),
   .wr_ready_o    (wr_ready_o),
   .wr_addr_i     (wr_addr_i),
   .wr_secure_i   (wr_secure_i),
   .rd_req_i      (rd_req_i),
   .rd_addr_i     (rd_addr_i),
   .rd_valid_o    (rd_valid_o),
   .rd_data_o     (rd_data_o),
   .enabled_o     (enabled_o),
   .pending_o     (pending_o),
   .active_o      (active_o)
);

// File: tb/tb_irq_bitmap_bank.sv
`timescale 1ns/1ps
module tb_irq_bitmap_bank;
   localparam int NUM_IRQ = 96;
   localparam int IDX_W   = 5;
   localparam int NEXT    = NUM_IRQ - 32;
   localparam int AW      = IDX_W + 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sec_disable = 1'b0;
   logic [NEXT-1:0] grp = '0;
   logic [2*NEXT-1:0] acc = '0;
   logic [NEXT-1:0] edge_cfg = '0;
   logic [NEXT-1:0] level = '0;
   logic            wr_req = 1'b0;
   logic            wr_ready;
   logic [AW-1:0]   wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic            wr_sec = 1'b0;
   logic            rd_req = 1'b0;
   logic [AW-1:0]   rd_addr = '0;
   logic            rd_sec = 1'b0;
   logic            rd_valid;
   logic [31:0]     rd_data;
   logic [NEXT-1:0] enabled, pending, active;

   always #2.5 clk = ~clk;

   irq_bitmap_bank #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .sec_disable_i(sec_disable),
      .grp_i(grp), .acc_code_i(acc), .edge_cfg_i(edge_cfg), .level_i(level),
      .wr_req_i(wr_req), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .wr_secure_i(wr_sec),
      .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_secure_i(rd_sec),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data),
      .enabled_o(enabled), .pending_o(pending), .active_o(active)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // Reference state built from the requirements
   logic [NEXT-1:0] m_en = '0, m_pl = '0, m_act = '0, lvl_s = '0;

   string       q_tag[$];
   logic [31:0] q_exp[$];

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mk_addr(int win, int w);
      return {3'(win), 5'(w)};
   endfunction

   // Reachable bits per R4..R8
   function automatic logic [31:0] perm(int win, int e, bit sec, bit rd);
      logic [31:0] m;
      if (sec || sec_disable) return '1;
      for (int k = 0; k < 32; k++) begin
         logic       g;
         logic [1:0] c;
         g = grp[e*32+k];
         c = acc[2*(e*32+k) +: 2];
         case (win)
            2:       m[k] = g | (c >= 2'd1);
            3:       m[k] = g | (c >= 2'd2);
            4, 5:    m[k] = rd ? (g | (c >= 2'd2)) : g;
            default: m[k] = g;
         endcase
      end
      return m;
   endfunction

   function automatic logic [31:0] model_word(int win, int e);
      logic [NEXT-1:0] eff;
      eff = m_pl | (lvl_s & ~edge_cfg);
      case (win / 2)
         0:       return m_en[e*32 +: 32];
         1:       return eff[e*32 +: 32];
         2:       return m_act[e*32 +: 32];
         default: return '0;
      endcase
   endfunction

   function automatic bit word_ok(int win, int w);
      return (w >= 1) && (w <= NEXT/32) && (win < 6);
   endfunction

   task automatic model_write(int win, int w, logic [31:0] d, bit sec);
      logic [31:0] m;
      int e;
      if (!word_ok(win, w)) return;
      e = w - 1;
      m = d & perm(win, e, sec, 1'b0);
      case (win)
         0: m_en[e*32 +: 32]  = m_en[e*32 +: 32] | m;
         1: m_en[e*32 +: 32]  = m_en[e*32 +: 32] & ~m;
         2: m_pl[e*32 +: 32]  = m_pl[e*32 +: 32] | m;
         3: m_pl[e*32 +: 32]  = m_pl[e*32 +: 32] & ~m;
         4: m_act[e*32 +: 32] = m_act[e*32 +: 32] | m;
         default: m_act[e*32 +: 32] = m_act[e*32 +: 32] & ~m;
      endcase
   endtask

   task automatic do_write(int win, int w, logic [31:0] d, bit sec);
      @(negedge clk);
      wr_req = 1'b1; wr_addr = mk_addr(win, w); wr_data = d; wr_sec = sec;
      @(posedge clk);
      model_write(win, w, d, sec);
      @(negedge clk);
      wr_req = 1'b0;
   endtask

   function automatic logic [31:0] expect_rd(int win, int w, bit sec);
      if (!word_ok(win, w)) return '0;
      return model_word(win, w-1) & perm(win, w-1, sec, 1'b1);
   endfunction

   // Driver side of the scoreboard
   task automatic do_read(int win, int w, bit sec, string tag);
      @(negedge clk);
      rd_req = 1'b1; rd_addr = mk_addr(win, w); rd_sec = sec;
      q_tag.push_back(tag);
      q_exp.push_back(expect_rd(win, w, sec));
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic set_lvl(logic [NEXT-1:0] v);
      @(negedge clk);
      level = v;
      @(posedge clk);
      m_pl  = m_pl | (edge_cfg & v & ~lvl_s);
      lvl_s = v;
      @(negedge clk);
   endtask

   // Monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (q_exp.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: actual unexpected rd_valid expected none");
         end else begin
            string       t;
            logic [31:0] e;
            t = q_tag.pop_front();
            e = q_exp.pop_front();
            chk(t, {32'h0, rd_data}, {32'h0, e});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R12 rd_valid", 64'(rd_valid), 64'd0);
      chk("R12 enabled", 64'(enabled), 64'd0);
      chk("R12 pending", 64'(pending), 64'd0);
      chk("R12 active", 64'(active), 64'd0);
      chk("R11 ready idle", 64'(wr_ready), 64'd1);

      for (int j = 0; j < NEXT; j++) acc[2*j +: 2] = 2'(j % 4);
      grp = {32'h0F0F_00FF, 32'hFFFF_0000};

      // R2 / R3 basic set and clear, secure
      do_write(0, 1, 32'hA5A5_0F0F, 1'b1);
      do_read(0, 1, 1'b1, "R2 set");
      do_read(1, 1, 1'b1, "R2 clear-window view");
      do_write(0, 1, 32'h0, 1'b1);
      do_read(0, 1, 1'b1, "R2 zero no effect");
      do_write(1, 1, 32'h0000_000F, 1'b1);
      do_read(0, 1, 1'b1, "R3 clear");
      do_write(1, 1, 32'h0, 1'b1);
      do_read(1, 1, 1'b1, "R3 zero no effect");

      // R1 out-of-range words and reserved windows
      do_write(0, 0, 32'hFFFF_FFFF, 1'b1);
      do_write(0, 3, 32'hFFFF_FFFF, 1'b1);
      do_write(6, 1, 32'hFFFF_FFFF, 1'b1);
      do_read(0, 0, 1'b1, "R1 word0");
      do_read(0, 3, 1'b1, "R1 beyond count");
      do_read(6, 1, 1'b1, "R1 reserved window");
      do_read(0, 1, 1'b1, "R1 unchanged");
      chk("R1 enabled_o", 64'(enabled), 64'(m_en));

      // Non-secure filtering on word 2
      do_write(0, 2, 32'hFFFF_FFFF, 1'b0);
      do_read(0, 2, 1'b1, "R5 ns enable write");
      do_read(0, 2, 1'b0, "R5 ns enable read");
      do_write(2, 2, 32'hFFFF_FFFF, 1'b0);
      do_read(2, 2, 1'b1, "R6 ns pend-set write");
      do_read(2, 2, 1'b0, "R6 ns pend-set read");
      do_write(3, 2, 32'hFFFF_FFFF, 1'b0);
      do_read(3, 2, 1'b1, "R7 ns pend-clear write");
      do_write(2, 2, 32'hFFFF_FFFF, 1'b1);
      do_read(3, 2, 1'b0, "R7 ns pend-clear read");
      do_write(4, 2, 32'hFFFF_FFFF, 1'b1);
      do_read(4, 2, 1'b0, "R8 ns active read");
      do_write(5, 2, 32'hFFFF_FFFF, 1'b0);
      do_read(4, 2, 1'b1, "R8 ns active write");

      // R4 security disabled
      @(negedge clk) sec_disable = 1'b1;
      do_write(1, 2, 32'hFFFF_FFFF, 1'b0);
      do_read(0, 2, 1'b0, "R4 disabled clear");
      do_write(0, 2, 32'h1234_5678, 1'b0);
      do_read(0, 2, 1'b0, "R4 disabled set");
      @(negedge clk) sec_disable = 1'b0;

      // R9 level-triggered merge on word 1
      edge_cfg = {32'h0, 32'h0000_FF00};
      set_lvl(64'h0000_0000_0000_000F);
      do_read(2, 1, 1'b1, "R9 level high");
      chk("R9 pending_o high", 64'(pending), 64'(m_pl | (lvl_s & ~edge_cfg)));
      set_lvl(64'h0);
      do_read(2, 1, 1'b1, "R9 level low");
      chk("R9 pending_o low", 64'(pending), 64'(m_pl));

      // R10 edge latch
      set_lvl(64'h0000_0000_0000_0F00);
      do_read(2, 1, 1'b1, "R10 rising latched");
      set_lvl(64'h0);
      do_read(2, 1, 1'b1, "R10 latch holds");
      set_lvl(64'h0000_0000_0000_0F00);
      do_write(3, 1, 32'h0000_0F00, 1'b1);
      repeat (4) @(negedge clk);
      do_read(2, 1, 1'b1, "R10 steady level no relatch");

      // R10 clear and edge in the same cycle on bit 12
      @(negedge clk);
      level[12] = 1'b1;
      wr_req = 1'b1; wr_addr = mk_addr(3, 1); wr_data = 32'h0000_1000; wr_sec = 1'b1;
      @(posedge clk);
      model_write(3, 1, 32'h0000_1000, 1'b1);
      m_pl  = m_pl | (edge_cfg & level & ~lvl_s);
      lvl_s = level;
      @(negedge clk);
      wr_req = 1'b0;
      chk("R10 edge beats clear", 64'(pending[12]), 64'd1);

      // R11 read precedence over write
      @(negedge clk);
      rd_req = 1'b1; rd_addr = mk_addr(0, 1); rd_sec = 1'b1;
      q_tag.push_back("R11 read during held write");
      q_exp.push_back(expect_rd(0, 1, 1'b1));
      wr_req = 1'b1; wr_addr = mk_addr(0, 1); wr_data = 32'h0000_0030; wr_sec = 1'b1;
      #1 chk("R11 ready low", 64'(wr_ready), 64'd0);
      @(posedge clk);
      @(negedge clk);
      rd_req = 1'b0;
      #1 chk("R11 ready high", 64'(wr_ready), 64'd1);
      @(posedge clk);
      model_write(0, 1, 32'h0000_0030, 1'b1);
      @(negedge clk);
      wr_req = 1'b0;
      do_read(0, 1, 1'b1, "R11 held write landed");
      chk("R11 enabled_o", 64'(enabled), 64'(m_en));

      repeat (4) @(negedge clk);
      chk("R11 queue drained", 64'(q_exp.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule